// File: doc/BRIEF.md
# Burst SRAM Address Strobe Front End

This block is the synchronous control front end of a pipelined burst static RAM. On every rising clock edge it looks at two active-low address strobes. One comes from the processor side and one from the controller side. It also samples an active-low chip enable, an active-low advance input and per-byte active-low write enables. When a strobe is accepted, the presented address is loaded into an address register. Its two lowest bits become a 2-bit burst counter. Without a strobe, the counter either steps through the aligned four-word group or holds.

The processor strobe wins when both strobes are low, but it counts only while chip enable is low. The controller strobe is never gated by chip enable. A processor strobe always starts a read. A controller strobe starts a write when any byte enable is low in the same cycle, and a read otherwise. Once a burst is open, later cycles without a strobe are writes when a byte enable is low and reads when none is. A small internal memory array stands behind the block so it can be used on its own. Read data comes out of a single output register one cycle after its address is in effect. The output driver is enabled only while output enable is low and read data is valid.

Top module: `burst_sram_front`

## Requirements
- R1: With `proc_strobe_n` and `chip_en_n` both low at an edge, `mem_addr` equals the `addr_in` sampled at that edge from the next cycle on.
- R2: With `proc_strobe_n` low but `chip_en_n` high, the processor strobe is ignored; with `ctrl_strobe_n` and `adv_n` high, `mem_addr` keeps its value.
- R3: With `ctrl_strobe_n` low at an edge and no processor strobe accepted, `mem_addr` takes the sampled `addr_in`, whatever the level of `chip_en_n`.
- R4: When both strobes are low and `chip_en_n` is low, only the processor strobe acts: the address loads, the cycle is a read, and low write enables in that cycle cause no write.
- R5: When both strobes are low and `chip_en_n` is high, the controller strobe acts and loads the address.
- R6: With no strobe accepted and `adv_n` low, `mem_addr[1:0]` increments and wraps from 3 to 0, while `mem_addr[AW-1:2]` stays fixed.
- R7: With no strobe accepted and `adv_n` high, `mem_addr` holds.
- R8: A read cycle at edge k makes `dq_out` equal to the memory word at the address driven after edge k, from edge k+1 on, and sets `dq_drive` when `oe_n` is low.
- R9: A write cycle captures `dq_in` at its edge. It stores byte b (bits 8b+7..8b) only where `wr_n[b]` is low, at the address driven after that edge. Unselected bytes keep their contents.
- R10: Once a burst is open, a cycle with no strobe and any `wr_n` bit low is a write to the address after advance or hold.
- R11: `dq_drive` is low whenever `oe_n` is high.
- R12: A synchronous active-high `rst` clears `mem_addr` to zero and leaves `dq_drive` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| chip_en_n | input | 1 | Chip enable gating the processor strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_in | input | AW | External address |
| wr_n | input | NB | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | DW | Data bus, inbound half |
| dq_out | output | DW | Data bus, outbound half |
| dq_drive | output | 1 | High when the data bus is driven |
| mem_addr | output | AW | Address presented to the memory array |

## Verification
The bench walks the burst counter across its wrap from 3 to 0 and checks that the upper bits stay fixed. A design that carried into bit 2 would leave the aligned group. It applies both strobes together with chip enable low and with chip enable high. Getting the priority or the gating wrong would either load a stale address or let the write enables of a processor cycle corrupt memory. That corruption is found by reading the word back two cycles later, after any stray write would have committed. It also writes a single byte over a full word to catch byte lanes that are not masked. It checks that the bus driver drops as soon as output enable rises and after a reset taken mid-operation.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

endpackage

// File: rtl/bsf_strobe_dec.sv
module bsf_strobe_dec
    import bsf_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          proc_n,
    input  logic          ctrl_n,
    input  logic          ce_n,
    input  logic          open_q,
    input  logic [NB-1:0] wr_n,
    output logic          load,
    output cyc_e          cyc
);

    logic proc_ok;
    logic ctrl_ok;
    logic any_wr;

    always_comb begin
        proc_ok = !proc_n && !ce_n;
        ctrl_ok = !ctrl_n && !proc_ok;
        any_wr  = |(~wr_n);
        load    = proc_ok || ctrl_ok;
        if (proc_ok) begin
            cyc = CYC_READ;
        end else if (ctrl_ok || open_q) begin
            cyc = any_wr ? CYC_WRITE : CYC_READ;
        end else begin
            cyc = CYC_IDLE;
        end
    end

endmodule

// File: rtl/bsf_addr_unit.sv
module bsf_addr_unit #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] addr_nx,
    output logic          open_q
);

    localparam int UW = AW - 2;

    typedef struct packed {
        logic [UW-1:0] upper;
        logic [1:0]    cnt;
        logic          open;
    } ast_t;

    ast_t s_d;
    ast_t s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.upper = addr_in[AW-1:2];
            s_d.cnt   = addr_in[1:0];
            s_d.open  = 1'b1;
        end else if (!adv_n) begin
            s_d.cnt = s_q.cnt + 2'd1;
        end
        addr_nx = {s_d.upper, s_d.cnt};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_q = {s_q.upper, s_q.cnt};
    assign open_q = s_q.open;

endmodule

// File: rtl/bsf_data_path.sv
module bsf_data_path
    import bsf_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_e          cyc,
    input  logic [AW-1:0] addr_nx,
    input  logic [AW-1:0] addr_q,
    input  logic [NB-1:0] wr_n,
    input  logic [DW-1:0] dq_in,
    input  logic          oe_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_drive
);

    localparam int DEPTH = 1 << AW;
    localparam int BW    = DW / NB;

    typedef struct packed {
        logic          wv;
        logic [AW-1:0] wa;
        logic [NB-1:0] wbe;
        logic [DW-1:0] wd;
        logic          rd_pend;
        logic          dvalid;
        logic [DW-1:0] dout;
    } dst_t;

    dst_t d_d;
    dst_t d_q;

    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        d_d         = d_q;
        d_d.wv      = (cyc == CYC_WRITE);
        d_d.wa      = addr_nx;
        d_d.wbe     = ~wr_n;
        d_d.wd      = dq_in;
        d_d.rd_pend = (cyc == CYC_READ);
        d_d.dvalid  = d_q.rd_pend;
        d_d.dout    = mem_q[addr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && d_q.wv) begin
            for (int b = 0; b < NB; b++) begin
                if (d_q.wbe[b]) begin
                    mem_q[d_q.wa][b*BW +: BW] <= d_q.wd[b*BW +: BW];
                end
            end
        end
    end

    assign dq_out   = d_q.dout;
    assign dq_drive = d_q.dvalid && !oe_n;

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
    import bsf_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          chip_en_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    input  logic [NB-1:0] wr_n,
    input  logic          oe_n,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_drive,
    output logic [AW-1:0] mem_addr
);

    logic          load;
    logic          open_q;
    cyc_e          cyc;
    logic [AW-1:0] addr_nx;

    bsf_strobe_dec #(.NB(NB)) u_dec (
        .proc_n (proc_strobe_n),
        .ctrl_n (ctrl_strobe_n),
        .ce_n   (chip_en_n),
        .open_q (open_q),
        .wr_n   (wr_n),
        .load   (load),
        .cyc    (cyc)
    );

    bsf_addr_unit #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .adv_n   (adv_n),
        .addr_in (addr_in),
        .addr_q  (mem_addr),
        .addr_nx (addr_nx),
        .open_q  (open_q)
    );

    bsf_data_path #(.AW(AW), .DW(DW), .NB(NB)) u_data (
        .clk      (clk),
        .rst      (rst),
        .cyc      (cyc),
        .addr_nx  (addr_nx),
        .addr_q   (mem_addr),
        .wr_n     (wr_n),
        .dq_in    (dq_in),
        .oe_n     (oe_n),
        .dq_out   (dq_out),
        .dq_drive (dq_drive)
    );

endmodule

// File: rtl/burst_sram_front_chk.sv
module burst_sram_front_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          proc_strobe_n,
    input logic          ctrl_strobe_n,
    input logic          chip_en_n,
    input logic          adv_n,
    input logic [AW-1:0] addr_in,
    input logic          oe_n,
    input logic          dq_drive,
    input logic [AW-1:0] mem_addr
);

    AST_PROC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !chip_en_n) |=> (mem_addr == $past(addr_in))); // R1

    AST_CE_GATE: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && chip_en_n && ctrl_strobe_n && adv_n) |=> $stable(mem_addr)); // R2

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strobe_n && (proc_strobe_n || chip_en_n)) |=> (mem_addr == $past(addr_in))); // R3

    AST_ADV_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((proc_strobe_n || chip_en_n) && ctrl_strobe_n && !adv_n) |=>
        ((mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])) &&
         (mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1))); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((proc_strobe_n || chip_en_n) && ctrl_strobe_n && adv_n) |=> $stable(mem_addr)); // R7

    AST_OE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_drive); // R11

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> ((mem_addr == '0) && (!dq_drive || oe_n))); // R12

endmodule

bind burst_sram_front burst_sram_front_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_en_n     (chip_en_n),
    .adv_n         (adv_n),
    .addr_in       (addr_in),
    .oe_n          (oe_n),
    .dq_drive      (dq_drive),
    .mem_addr      (mem_addr)
);

// File: tb/burst_sram_front_bench.sv
`timescale 1ns/1ps
module burst_sram_front_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          proc_strobe_n;
    logic          ctrl_strobe_n;
    logic          chip_en_n;
    logic          adv_n;
    logic [AW-1:0] addr_in;
    logic [NB-1:0] wr_n;
    logic          oe_n;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_drive;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_sram_front #(.AW(AW), .DW(DW), .NB(NB)) u_burst_sram_front (
        .clk           (clk),
        .rst           (rst),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .addr_in       (addr_in),
        .wr_n          (wr_n),
        .oe_n          (oe_n),
        .dq_in         (dq_in),
        .dq_out        (dq_out),
        .dq_drive      (dq_drive),
        .mem_addr      (mem_addr)
    );

    typedef struct packed {
        logic       p;
        logic       c;
        logic       e;
        logic       a;
        logic [5:0] ad;
        logic [5:0] ex;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 6'h2D, 6'h2D},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 6'h2E},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 6'h2F},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 6'h2C},
        '{1'b1, 1'b1, 1'b0, 1'b1, 6'h3F, 6'h2C},
        '{1'b0, 1'b1, 1'b1, 1'b1, 6'h13, 6'h2C},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'h13, 6'h13},
        '{1'b0, 1'b0, 1'b0, 1'b1, 6'h3A, 6'h3A},
        '{1'b0, 1'b0, 1'b1, 1'b1, 6'h07, 6'h07},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 6'h04}
    };

    function automatic string row_tag(int i);
        case (i)
            0:       return "R1";
            4:       return "R7";
            5:       return "R2";
            6:       return "R3";
            7:       return "R4";
            8:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1;
        ctrl_strobe_n = 1'b1;
        chip_en_n     = 1'b0;
        adv_n         = 1'b1;
        addr_in       = '0;
        wr_n          = '1;
        dq_in         = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        oe_n = 1'b0;
        rst  = 1'b1;
        @(negedge clk);
        tick();
        tick();
        chk("R12 addr", {10'd0, mem_addr}, 16'h0000);
        chk("R12 drive", {15'd0, dq_drive}, 16'h0000);
        rst  = 1'b0;
        oe_n = 1'b1;

        // address register and burst counter vectors
        for (int i = 0; i < NV; i++) begin
            proc_strobe_n = TBL[i].p;
            ctrl_strobe_n = TBL[i].c;
            chip_en_n     = TBL[i].e;
            adv_n         = TBL[i].a;
            addr_in       = TBL[i].ad;
            tick();
            chk(row_tag(i), {10'd0, mem_addr}, {10'd0, TBL[i].ex});
        end

        // R9: controller strobe write, chip enable high does not matter
        idle();
        ctrl_strobe_n = 1'b0;
        chip_en_n     = 1'b1;
        addr_in       = 6'h10;
        wr_n          = 2'b00;
        dq_in         = 16'hA5C3;
        tick();
        // R10: burst write continuation to 0x11
        idle();
        adv_n = 1'b0;
        wr_n  = 2'b00;
        dq_in = 16'h1111;
        tick();
        // R9: low byte only at held address 0x11
        idle();
        wr_n  = 2'b10;
        dq_in = 16'h22EF;
        tick();
        // R4: both strobes, processor wins, write enables ignored
        idle();
        proc_strobe_n = 1'b0;
        ctrl_strobe_n = 1'b0;
        addr_in       = 6'h10;
        wr_n          = 2'b00;
        dq_in         = 16'hFFFF;
        tick();
        chk("R4 addr", {10'd0, mem_addr}, 16'h0010);
        idle();
        oe_n = 1'b0;
        tick();
        chk("R8 data", dq_out, 16'hA5C3);
        chk("R8 drive", {15'd0, dq_drive}, 16'h0001);
        tick();
        chk("R4 no write", dq_out, 16'hA5C3);
        oe_n = 1'b1;
        #1;
        chk("R11 drive", {15'd0, dq_drive}, 16'h0000);
        oe_n = 1'b0;

        // burst read across 0x10 and 0x11
        idle();
        proc_strobe_n = 1'b0;
        addr_in       = 6'h10;
        tick();
        idle();
        adv_n = 1'b0;
        tick();
        chk("R8 burst first", dq_out, 16'hA5C3);
        tick();
        chk("R9 R10 burst second", dq_out, 16'h11EF);
        chk("R6 burst addr", {10'd0, mem_addr}, 16'h0012);

        // R12: reset in the middle of a burst
        rst = 1'b1;
        tick();
        chk("R12 addr mid", {10'd0, mem_addr}, 16'h0000);
        chk("R12 drive mid", {15'd0, dq_drive}, 16'h0000);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule